// File: doc/BRIEF.md
# Banked Lookup Request Scheduler

This block sits in front of a cache whose sets are spread over several independent banks. It takes one lookup request per cycle on a valid/ready port. The bank is chosen from the low bits of the set index, so a set always stays inside one bank and each bank holds many sets. Each bank has its own in-order queue and works independently of the others. A bank can begin a new lookup every `QUEUE_INTERVAL` cycles. That interval may be shorter than the lookup itself, so one bank can run as a pipeline.

A request becomes due a fixed number of cycles after it is accepted. That number is the transfer delay to its bank, then any wait behind earlier work in the same bank, then the lookup delay. When it is due, the request's tag comes back on the response port. The tag and data arrays, replacement and miss handling are not modelled here.

A request is turned away only when its own bank is already full. The requester must hold the request and retry. When several banks have responses due in the same cycle, one shared output picks among them in fixed priority.

Top module: `mbank_sched`

## Requirements
- R1: The target bank is `req_addr[LINE_OFF +: BANK_W]` (bits [3:2] with defaults). No other address bit affects bank choice or timing.
- R2: Requests to different banks are timed independently. Work queued in one bank adds no delay to a request in another bank.
- R3: Responses from one bank come out in the order that bank accepted the requests.
- R4: `req_ready` is low in a cycle only when the addressed bank already holds `BANK_DEPTH` entries. A full bank does not lower `req_ready` for addresses of other banks.
- R5: A request accepted into an empty bank in cycle t has its response on the port in cycle t + PROP_LAT + LOOKUP_LAT (t+6 with defaults), unless a lower bank wins that cycle.
- R6: When the bank still holds earlier entries, a request starts at the later of two times: its arrival (acceptance + PROP_LAT), or the previous entry's start + QUEUE_INTERVAL. It is due LOOKUP_LAT after its start. With QUEUE_INTERVAL < LOOKUP_LAT, several lookups overlap in one bank.
- R7: When several banks are due in one cycle, the lowest bank index is served. The others wait one cycle per winner, and their waiting does not shift the start time of later requests.
- R8: An entry stops counting towards occupancy when its response is emitted. A full bank raises `req_ready` again in the cycle after its oldest response.
- R9: Reset empties every bank queue. After reset `rsp_valid` is low and `req_ready` is high for every bank until new requests arrive.
- R10: `rsp_bank` gives the index of the bank whose response is on the port, and `rsp_id` carries that request's `req_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank has room; request taken when both are high |
| req_addr | input | ADDR_W | Lookup address |
| req_id | input | ID_W | Tag returned with the response |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_id | output | ID_W | Tag of the finished request |
| rsp_bank | output | BANK_W | Bank that produced the response |

## Verification
The response of an uncontended request is due PROP_LAT + LOOKUP_LAT cycles after the accepting cycle. Each same-bank follower adds its queue-interval wait on top of that. Each arbitration loss adds one cycle. `req_ready` reacts in the same cycle as the address, and only in the cycle after a response frees a slot. The bench records the cycle in which each tag was accepted and the cycle in which it appears on the response port. It compares the difference with latencies worked out by hand from R5 to R7. It samples `req_ready` one time unit after driving the address, away from the clock edge.

// File: rtl/mbsched_pkg.sv
package mbsched_pkg;
  localparam int TIME_W = 16;
  typedef logic [TIME_W-1:0] tick_t;

  // now has reached or passed due (wrap-safe)
  function automatic logic tick_reached(tick_t now, tick_t due);
    tick_t d;
    d = now - due;
    return ~d[TIME_W-1];
  endfunction

  // a strictly later than b (wrap-safe)
  function automatic logic tick_after(tick_t a, tick_t b);
    tick_t d;
    d = a - b;
    return (d != '0) && ~d[TIME_W-1];
  endfunction

  // start slot: arrival, or previous start plus gap if bank still occupied
  function automatic tick_t bank_start(tick_t arrive, tick_t prev, logic busy, tick_t gap);
    tick_t slot;
    slot = prev + gap;
    return (busy && tick_after(slot, arrive)) ? slot : arrive;
  endfunction
endpackage

// File: rtl/mbsched_arb.sv
module mbsched_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  for (genvar i = 0; i < N; i++) begin : g_prio
    localparam logic [N-1:0] LOWER = N'((1 << i) - 1);
    assert_grant_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (req[i] && ((req & LOWER) == '0)));
  end
endmodule

// File: rtl/mbsched_bank.sv
module mbsched_bank import mbsched_pkg::*; #(
  parameter int DEPTH          = 4,
  parameter int ID_W           = 4,
  parameter int PROP_LAT       = 2,
  parameter int LOOKUP_LAT     = 4,
  parameter int QUEUE_INTERVAL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tick_t           now,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic            pop,
  output logic            full,
  output logic            due,
  output logic [ID_W-1:0] head_id
);
  localparam int    PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int    CNT_W    = $clog2(DEPTH + 1);
  localparam tick_t PROP_T   = tick_t'(PROP_LAT);
  localparam tick_t LOOKUP_T = tick_t'(LOOKUP_LAT);
  localparam tick_t GAP_T    = tick_t'(QUEUE_INTERVAL);

  logic [ID_W-1:0]  id_mem  [DEPTH];
  tick_t            due_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  tick_t            last_start, new_start, head_due_t;
  logic             busy_after_retire;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // the entry retiring this cycle no longer counts as an occupant
  assign busy_after_retire = pop ? (count > CNT_W'(1)) : (count != '0);
  assign new_start  = bank_start(now + PROP_T, last_start, busy_after_retire, GAP_T);
  assign head_due_t = due_mem[rd_ptr];
  assign head_id    = id_mem[rd_ptr];
  assign full       = (count == CNT_W'(DEPTH));
  assign due        = (count != '0) && tick_reached(now, head_due_t);

  always_ff @(posedge clk) begin
    if (push) begin
      id_mem[wr_ptr]  <= push_id;
      due_mem[wr_ptr] <= new_start + LOOKUP_T;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      last_start <= '0;
    end else begin
      if (push) begin
        wr_ptr     <= ptr_next(wr_ptr);
        last_start <= new_start;
      end
      if (pop) rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)));

  assert_issue_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && busy_after_retire) |=> !tick_after(GAP_T, last_start - $past(last_start)));

  assert_fifo_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count > CNT_W'(1)) |=> !tick_after($past(head_due_t), head_due_t));
endmodule

// File: rtl/mbank_sched.sv
module mbank_sched import mbsched_pkg::*; #(
  parameter int NUM_BANKS      = 4,
  parameter int BANK_DEPTH     = 4,
  parameter int PROP_LAT       = 2,
  parameter int LOOKUP_LAT     = 4,
  parameter int QUEUE_INTERVAL = 2,
  parameter int ADDR_W         = 16,
  parameter int ID_W           = 4,
  parameter int LINE_OFF       = 2,
  localparam int BANK_W        = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [BANK_W-1:0] rsp_bank
);
  tick_t                now;
  logic [BANK_W-1:0]    req_bank;
  logic                 accept;
  logic [NUM_BANKS-1:0] bank_push, bank_full, bank_due, grant;
  logic [ID_W-1:0]      head_id [NUM_BANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + tick_t'(1);
  end

  assign req_bank  = req_addr[LINE_OFF +: BANK_W];
  assign req_ready = !bank_full[req_bank];
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_push[b] = accept && (req_bank == BANK_W'(b));
    mbsched_bank #(
      .DEPTH(BANK_DEPTH), .ID_W(ID_W), .PROP_LAT(PROP_LAT),
      .LOOKUP_LAT(LOOKUP_LAT), .QUEUE_INTERVAL(QUEUE_INTERVAL)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .now(now),
      .push(bank_push[b]), .push_id(req_id), .pop(grant[b]),
      .full(bank_full[b]), .due(bank_due[b]), .head_id(head_id[b])
    );
  end

  mbsched_arb #(.N(NUM_BANKS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(bank_due), .grant(grant)
  );

  assign rsp_valid = |grant;

  always_comb begin
    rsp_id   = '0;
    rsp_bank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (grant[b]) begin
        rsp_id   = head_id[b];
        rsp_bank = BANK_W'(b);
      end
    end
  end

  assert_accept_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_push) && ((bank_push & bank_full) == '0));
endmodule

// File: tb/sim_mbank_sched.sv
module sim_mbank_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_id = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_id;
  logic [1:0]  rsp_bank;

  int checks = 0, errors = 0, cyc = 0, post_rst_rsp = 0;
  int acc_cyc [16];
  int rsp_cyc [16];
  int rsp_bk  [16];
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbank_sched u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_id(req_id), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .rsp_bank(rsp_bank)
  );

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_cyc[rsp_id] = cyc;
      rsp_bk[rsp_id]  = int'(rsp_bank);
      post_rst_rsp++;
    end
  end

  // {gap before, addr, id, expected latency}
  localparam logic [31:0] VEC [8] = '{
    32'h00123B16, 32'h00000827, 32'h00FFFA38, 32'h00000C46,
    32'h005A5F57, 32'h14000466, 32'h00777578, 32'h00ABC086
  };
  localparam int VBANK [8] = '{2, 2, 2, 3, 3, 1, 1, 0};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [3:0] id, output logic rdy);
    @(negedge clk);
    req_valid = v; req_addr = a; req_id = id;
    #1;
    rdy = req_ready;
    if (v && rdy) acc_cyc[id] = cyc;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    logic r;
    for (int k = 0; k < n; k++) step(1'b0, 16'h0, 4'h0, r);
  endtask

  task automatic clear_logs();
    for (int k = 0; k < 16; k++) begin
      acc_cyc[k] = -100; rsp_cyc[k] = -1; rsp_bk[k] = -1;
    end
  endtask

  initial begin
    logic r;
    clear_logs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R9 reset rsp_valid", int'(rsp_valid), 0);
    check("R9 reset req_ready", int'(req_ready), 1);

    // table: R1 R2 R3 R5 R6 R7 R10
    for (int v = 0; v < 8; v++) begin
      idle(int'(VEC[v][31:24]));
      step(1'b1, VEC[v][23:8], VEC[v][7:4], r);
      check("R4 ready for table entry", int'(r), 1);
    end
    idle(20);
    for (int v = 0; v < 8; v++) begin
      int id;
      id = int'(VEC[v][7:4]);
      check($sformatf("R5/R6/R7 latency id%0d", id), rsp_cyc[id] - acc_cyc[id], int'(VEC[v][3:0]));
      check($sformatf("R1/R10 bank id%0d", id), rsp_bk[id], VBANK[v]);
    end
    check("R3 order bank2", int'(rsp_cyc[1] < rsp_cyc[2] && rsp_cyc[2] < rsp_cyc[3]), 1);
    check("R2 bank3 unaffected by bank2", rsp_cyc[4] - acc_cyc[4], 6);

    // fill bank0: R4 R8
    clear_logs();
    step(1'b1, 16'h0000, 4'd9,  r);
    step(1'b1, 16'h0010, 4'd10, r);
    step(1'b1, 16'h0020, 4'd11, r);
    step(1'b1, 16'h0030, 4'd12, r);
    step(1'b1, 16'h0040, 4'd13, r);
    check("R4 full bank0 rejects", int'(r), 0);
    step(1'b1, 16'h0104, 4'd14, r);
    check("R4 bank1 accepted while bank0 full", int'(r), 1);
    step(1'b1, 16'h0040, 4'd13, r);
    check("R8 still full in response cycle", int'(r), 0);
    step(1'b1, 16'h0040, 4'd13, r);
    check("R8 slot freed after response", int'(r), 1);
    idle(20);
    check("R6 id9 latency",  rsp_cyc[9]  - acc_cyc[9],  6);
    check("R6 id10 latency", rsp_cyc[10] - acc_cyc[10], 7);
    check("R6 id11 latency", rsp_cyc[11] - acc_cyc[11], 8);
    check("R6 id12 latency", rsp_cyc[12] - acc_cyc[12], 9);
    check("R6 id13 latency after retry", rsp_cyc[13] - acc_cyc[13], 7);
    check("R2 id14 latency", rsp_cyc[14] - acc_cyc[14], 6);

    // reset while bank2 full: R9
    step(1'b1, 16'h0008, 4'd1, r);
    step(1'b1, 16'h0018, 4'd2, r);
    step(1'b1, 16'h0028, 4'd3, r);
    step(1'b1, 16'h0038, 4'd4, r);
    step(1'b1, 16'h0048, 4'd5, r);
    check("R4 bank2 full before reset", int'(r), 0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    req_addr = 16'h0048;
    #1;
    check("R9 bank2 ready after reset", int'(req_ready), 1);
    post_rst_rsp = 0;
    idle(15);
    check("R9 no responses after reset", post_rst_rsp, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule